// File: doc/BRIEF.md
# Virtual Interrupt-Controller Page Access Filter

This block sits in the guest memory path of a virtualising processor core. Each time a guest touches the 4 KiB page that holds the interrupt controller's registers, the block receives the page offset, the access length, the direction and whether the access happens while an event is being delivered. It also receives three enables: TPR shadowing, register virtualization and virtual-interrupt delivery. From these it returns exactly one verdict. Either the access is remapped into a virtual register page, or the block requests a virtual-machine exit and supplies a qualification word.

An accepted write can also raise single-cycle trap flags. These mark a task-priority update, an end-of-interrupt update or a generic virtual-register write, and later trap handling acts on them. While any such trap is outstanding, the block remembers the offset of the last accepted access. It refuses any access to a different offset until the trap handler acknowledges. The block holds no register contents and takes no part in exit processing.

Top module: `vapic_filter`

## Requirements
- R1: An access whose first byte and last byte fall in different naturally aligned 32-bit words exits.
- R2: An access exits when TPR shadowing is disabled, when its length is 0 or greater than 4, or when its offset is 0x400 or above.
- R3: Once an accepted write has raised a trap, and until `trap_ack` is seen, an access to an offset other than the last accepted one exits. An access to the same offset is judged by the normal rules.
- R4: With register virtualization disabled, a read is accepted only at offset 0x080 exactly.
- R5: With register virtualization enabled, a read is accepted only when offset & 0x3FC is one of these: 0x020, 0x030, 0x080, 0x0B0, 0x0D0, 0x0E0, 0x0F0, 0x100–0x270 in steps of 0x10, 0x280, 0x300–0x380 in steps of 0x10, or 0x3E0. Any other offset exits.
- R6: A write at offset 0x080 exactly is accepted whatever the register-virtualization and delivery enables are. It pulses `tpr_trap` and not `regw_trap`.
- R7: A write at offset 0x0B0 exactly pulses `eoi_trap` when virtual-interrupt delivery is enabled, and never pulses it otherwise.
- R8: A write whose offset & 0x3FC is 0x0B0 or 0x300 is accepted if delivery or register virtualization is enabled. These writes need register virtualization: offsets 0x020, 0x080 (other than exactly 0x080), 0x0D0, 0x0E0, 0x0F0, 0x280, 0x310–0x380 in steps of 0x10, and 0x3E0. All other writes exit. Every write accepted under this rule pulses `regw_trap`.
- R9: `exit_qual` carries the offset in bits [11:0] and an access code in bits [15:12]. The code is 3 when `acc_in_event` is set, otherwise 0 for a read and 1 for a write.
- R10: Every cycle with `acc_valid` produces, one clock later, either `remap_valid` or `exit_valid`, never both. Neither is raised otherwise. `remap_addr` is `{vpage_frame, offset}`.
- R11: After reset all outputs are low and no trap is outstanding. `trap_ack` clears the outstanding state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_offset | input | 12 | Byte offset within the controller page |
| acc_len | input | 3 | Access length in bytes |
| acc_write | input | 1 | 1 for write, 0 for read |
| acc_in_event | input | 1 | Access occurs during event delivery |
| en_tpr_shadow | input | 1 | TPR shadowing enable |
| en_reg_virt | input | 1 | Register virtualization enable |
| en_vint_dlv | input | 1 | Virtual-interrupt delivery enable |
| vpage_frame | input | ADDR_W-12 | Frame number of the virtual register page |
| trap_ack | input | 1 | Trap handler has consumed the outstanding trap |
| remap_valid | output | 1 | Access accepted; `remap_addr` is valid |
| remap_addr | output | ADDR_W | Remapped physical address |
| exit_valid | output | 1 | Access must exit |
| exit_qual | output | 16 | Exit qualification word |
| tpr_trap | output | 1 | Task-priority update trap pulse |
| eoi_trap | output | 1 | End-of-interrupt update trap pulse |
| regw_trap | output | 1 | Generic virtual-register write trap pulse |

## Verification
Every verdict and trap pulse is registered. It therefore appears in the cycle after the one where the access is presented, and it is held for that single cycle. The scoreboard stamps each expected item with the cycle number in which its result is due. The monitor, sampling on the falling edge, pops an item only when the cycle count reaches that stamp. It treats any verdict seen with no item due as a failure. Accesses are issued back to back, so the outstanding-trap rule is also tested with an access in the very cycle after the trap is raised.

// File: rtl/vapic_pkg.sv
package vapic_pkg;

    localparam int PAGE_BITS = 12;
    localparam int LEN_W     = 3;
    localparam int CODE_W    = 4;
    localparam int QUAL_W    = PAGE_BITS + CODE_W;
    localparam int MAX_LEN   = 4;
    localparam int WIN_LIMIT = 'h400;

    localparam logic [PAGE_BITS-1:0] OFS_ID    = 12'h020;
    localparam logic [PAGE_BITS-1:0] OFS_VER   = 12'h030;
    localparam logic [PAGE_BITS-1:0] OFS_TPR   = 12'h080;
    localparam logic [PAGE_BITS-1:0] OFS_EOI   = 12'h0B0;
    localparam logic [PAGE_BITS-1:0] OFS_LDR   = 12'h0D0;
    localparam logic [PAGE_BITS-1:0] OFS_DFR   = 12'h0E0;
    localparam logic [PAGE_BITS-1:0] OFS_SVR   = 12'h0F0;
    localparam logic [PAGE_BITS-1:0] OFS_BANKS = 12'h100;
    localparam logic [PAGE_BITS-1:0] OFS_BANKE = 12'h270;
    localparam logic [PAGE_BITS-1:0] OFS_ESR   = 12'h280;
    localparam logic [PAGE_BITS-1:0] OFS_ICRL  = 12'h300;
    localparam logic [PAGE_BITS-1:0] OFS_ICRH  = 12'h310;
    localparam logic [PAGE_BITS-1:0] OFS_LVTS  = 12'h320;
    localparam logic [PAGE_BITS-1:0] OFS_TINIT = 12'h380;
    localparam logic [PAGE_BITS-1:0] OFS_TDIV  = 12'h3E0;

    typedef enum logic [CODE_W-1:0] {
        KIND_LIN_RD = 4'h0,
        KIND_LIN_WR = 4'h1,
        KIND_EVENT  = 4'h3
    } acc_kind_e;

    typedef struct packed {
        logic [PAGE_BITS-1:0] off;
        logic [LEN_W-1:0]     len;
        logic                 wr;
        logic                 evt;
    } access_t;

    typedef struct packed {
        logic ok;
        logic tpr;
        logic eoi;
        logic regw;
    } verdict_t;

    // word-aligned key: the two low offset bits do not select a register
    function automatic logic [PAGE_BITS-1:0] reg_key(input logic [PAGE_BITS-1:0] off);
        return {off[PAGE_BITS-1:2], 2'b00};
    endfunction

    // key sits on a 16-byte register slot between lo and hi
    function automatic logic in_slots(input logic [PAGE_BITS-1:0] k,
                                      input logic [PAGE_BITS-1:0] lo,
                                      input logic [PAGE_BITS-1:0] hi);
        return (k[3:0] == 4'h0) && (k >= lo) && (k <= hi);
    endfunction

    function automatic acc_kind_e kind_of(input access_t a);
        if (a.evt)     return KIND_EVENT;
        else if (a.wr) return KIND_LIN_WR;
        else           return KIND_LIN_RD;
    endfunction

endpackage

// File: rtl/vapic_gate.sv
// Checks shared by reads and writes: size, word crossing, window,
// shadow enable and the outstanding-trap offset lock.
module vapic_gate
    import vapic_pkg::*;
(
    input  access_t              acc,
    input  logic                 en_tpr_shadow,
    input  logic                 lock_active,
    input  logic [PAGE_BITS-1:0] lock_off,
    output logic                 must_exit
);
    localparam int SUM_W = PAGE_BITS + 1;

    logic [SUM_W-1:0] last_byte;
    logic             bad_len;
    logic             crosses;
    logic             off_window;
    logic             lock_miss;

    always_comb begin
        last_byte  = SUM_W'(acc.off) + SUM_W'(acc.len) - SUM_W'(1);
        bad_len    = (acc.len == '0) || (int'(acc.len) > MAX_LEN);
        crosses    = (last_byte[SUM_W-1:2] != {1'b0, acc.off[PAGE_BITS-1:2]});
        off_window = (int'(acc.off) >= WIN_LIMIT);
        lock_miss  = lock_active && (acc.off != lock_off);
        must_exit  = bad_len || crosses || off_window || !en_tpr_shadow || lock_miss;
    end
endmodule

// File: rtl/vapic_rd_check.sv
// Read allow decision.
module vapic_rd_check
    import vapic_pkg::*;
(
    input  logic [PAGE_BITS-1:0] off,
    input  logic                 en_reg_virt,
    output logic                 rd_ok
);
    logic [PAGE_BITS-1:0] k;
    logic                 listed;

    always_comb begin
        k = reg_key(off);
        unique case (k)
            OFS_ID, OFS_VER, OFS_TPR, OFS_EOI, OFS_LDR, OFS_DFR,
            OFS_SVR, OFS_ESR, OFS_TDIV: listed = 1'b1;
            default: listed = in_slots(k, OFS_BANKS, OFS_BANKE) ||
                              in_slots(k, OFS_ICRL, OFS_TINIT);
        endcase
        if (!en_reg_virt) rd_ok = (off == OFS_TPR);
        else              rd_ok = listed;
    end
endmodule

// File: rtl/vapic_wr_check.sv
// Write allow decision and trap selection.
module vapic_wr_check
    import vapic_pkg::*;
(
    input  logic [PAGE_BITS-1:0] off,
    input  logic                 en_reg_virt,
    input  logic                 en_vint_dlv,
    output verdict_t             vd
);
    logic [PAGE_BITS-1:0] k;
    logic                 grp_virt;
    logic                 grp_either;

    always_comb begin
        k          = reg_key(off);
        grp_either = (k == OFS_EOI) || (k == OFS_ICRL);
        unique case (k)
            OFS_ID, OFS_TPR, OFS_LDR, OFS_DFR, OFS_SVR,
            OFS_ESR, OFS_ICRH, OFS_TDIV: grp_virt = 1'b1;
            default: grp_virt = in_slots(k, OFS_LVTS, OFS_TINIT);
        endcase

        vd = '0;
        if (off == OFS_TPR) begin
            vd.ok  = 1'b1;
            vd.tpr = 1'b1;
        end else begin
            if (grp_either)    vd.ok = en_vint_dlv || en_reg_virt;
            else if (grp_virt) vd.ok = en_reg_virt;
            vd.regw = vd.ok;
            vd.eoi  = vd.ok && en_vint_dlv && (off == OFS_EOI);
        end
    end
endmodule

// File: rtl/vapic_filter.sv
module vapic_filter
    import vapic_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        acc_valid,
    input  logic [PAGE_BITS-1:0]        acc_offset,
    input  logic [LEN_W-1:0]            acc_len,
    input  logic                        acc_write,
    input  logic                        acc_in_event,
    input  logic                        en_tpr_shadow,
    input  logic                        en_reg_virt,
    input  logic                        en_vint_dlv,
    input  logic [ADDR_W-PAGE_BITS-1:0] vpage_frame,
    input  logic                        trap_ack,
    output logic                        remap_valid,
    output logic [ADDR_W-1:0]           remap_addr,
    output logic                        exit_valid,
    output logic [QUAL_W-1:0]           exit_qual,
    output logic                        tpr_trap,
    output logic                        eoi_trap,
    output logic                        regw_trap
);
    localparam int FRAME_W = ADDR_W - PAGE_BITS;

    access_t              acc;
    logic                 gate_exit;
    logic                 rd_ok;
    verdict_t             wr_vd;
    verdict_t             final_vd;
    logic                 accept;
    logic                 any_trap;
    logic                 lock_active;
    logic [PAGE_BITS-1:0] lock_off;

    assign acc = '{off: acc_offset, len: acc_len, wr: acc_write, evt: acc_in_event};

    vapic_gate u_gate (
        .acc          (acc),
        .en_tpr_shadow(en_tpr_shadow),
        .lock_active  (lock_active),
        .lock_off     (lock_off),
        .must_exit    (gate_exit)
    );

    vapic_rd_check u_rd (
        .off        (acc.off),
        .en_reg_virt(en_reg_virt),
        .rd_ok      (rd_ok)
    );

    vapic_wr_check u_wr (
        .off        (acc.off),
        .en_reg_virt(en_reg_virt),
        .en_vint_dlv(en_vint_dlv),
        .vd         (wr_vd)
    );

    always_comb begin
        final_vd = '0;
        if (!gate_exit) begin
            if (acc.wr) final_vd = wr_vd;
            else        final_vd.ok = rd_ok;
        end
        accept   = acc_valid && final_vd.ok;
        any_trap = final_vd.tpr || final_vd.eoi || final_vd.regw;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            remap_valid <= 1'b0;
            remap_addr  <= '0;
            exit_valid  <= 1'b0;
            exit_qual   <= '0;
            tpr_trap    <= 1'b0;
            eoi_trap    <= 1'b0;
            regw_trap   <= 1'b0;
            lock_active <= 1'b0;
            lock_off    <= '0;
        end else begin
            remap_valid <= accept;
            exit_valid  <= acc_valid && !final_vd.ok;
            tpr_trap    <= accept && final_vd.tpr;
            eoi_trap    <= accept && final_vd.eoi;
            regw_trap   <= accept && final_vd.regw;
            if (acc_valid) begin
                remap_addr <= {FRAME_W'(vpage_frame), acc.off};
                exit_qual  <= {kind_of(acc), acc.off};
            end
            if (accept) lock_off <= acc.off;
            if (accept && any_trap) lock_active <= 1'b1;
            else if (trap_ack)      lock_active <= 1'b0;
        end
    end
endmodule

// File: rtl/vapic_filter_chk.sv
module vapic_filter_chk
    import vapic_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        acc_valid,
    input logic [PAGE_BITS-1:0]        acc_offset,
    input logic [LEN_W-1:0]            acc_len,
    input logic                        acc_write,
    input logic                        acc_in_event,
    input logic                        en_tpr_shadow,
    input logic                        en_reg_virt,
    input logic                        en_vint_dlv,
    input logic [ADDR_W-PAGE_BITS-1:0] vpage_frame,
    input logic                        trap_ack,
    input logic                        remap_valid,
    input logic [ADDR_W-1:0]           remap_addr,
    input logic                        exit_valid,
    input logic [QUAL_W-1:0]           exit_qual,
    input logic                        tpr_trap,
    input logic                        eoi_trap,
    input logic                        regw_trap
);
    logic [3:0] end_pos;
    assign end_pos = {2'b00, acc_offset[1:0]} + {1'b0, acc_len};

    AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (rst)
        !(remap_valid && exit_valid)); // R10
    AST_VERDICT_DUE: assert property (@(posedge clk) disable iff (rst)
        acc_valid |=> (remap_valid || exit_valid)); // R10
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |=> !(remap_valid || exit_valid)); // R10
    AST_WORD_CROSS: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && end_pos > 4'd4) |=> exit_valid); // R1
    AST_SHADOW_OFF: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !en_tpr_shadow) |=> exit_valid); // R2
    AST_TRAP_ON_REMAP: assert property (@(posedge clk) disable iff (rst)
        (tpr_trap || eoi_trap || regw_trap) |-> remap_valid); // R8
    AST_TPR_SLOT: assert property (@(posedge clk) disable iff (rst)
        tpr_trap |-> (remap_addr[PAGE_BITS-1:0] == 12'h080 && !regw_trap)); // R6
    AST_EOI_GATED: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !en_vint_dlv) |=> !eoi_trap); // R7
    AST_QUAL_OFFSET: assert property (@(posedge clk) disable iff (rst)
        acc_valid |=> (!exit_valid || exit_qual[PAGE_BITS-1:0] == $past(acc_offset))); // R9
endmodule

bind vapic_filter vapic_filter_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/vapic_filter_bench.sv
`timescale 1ns/1ps
module vapic_filter_bench;
    import vapic_pkg::*;

    localparam int ADDR_W = 32;
    localparam int FW     = ADDR_W - PAGE_BITS;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic acc_valid = 1'b0;
    logic [PAGE_BITS-1:0] acc_offset = '0;
    logic [LEN_W-1:0] acc_len = '0;
    logic acc_write = 1'b0, acc_in_event = 1'b0;
    logic en_tpr_shadow = 1'b0, en_reg_virt = 1'b0, en_vint_dlv = 1'b0;
    logic [FW-1:0] vpage_frame = 20'hABCDE;
    logic trap_ack = 1'b0;
    logic remap_valid, exit_valid, tpr_trap, eoi_trap, regw_trap;
    logic [ADDR_W-1:0] remap_addr;
    logic [QUAL_W-1:0] exit_qual;

    always #2 clk = ~clk;

    vapic_filter #(.ADDR_W(ADDR_W)) u_vapic_filter (.*);

    typedef struct {
        logic rv, ev, tp, eo, rw;
        logic [ADDR_W-1:0] addr;
        logic [QUAL_W-1:0] qual;
        int due;
        string tag;
    } exp_t;

    exp_t q[$];
    int checks = 0, errors = 0, cyc = 0;
    logic sh = 0, vr = 0, vi = 0;
    logic m_lock = 0;
    logic [11:0] m_off = '0;

    always @(posedge clk) cyc <= cyc + 1;

    // R5/R8 register sets, from the requirement text
    function automatic logic rd_listed(input logic [11:0] k);
        if (k inside {12'h020, 12'h030, 12'h080, 12'h0B0, 12'h0D0, 12'h0E0,
                      12'h0F0, 12'h280, 12'h3E0}) return 1;
        if (k[3:0] == 0 && k >= 12'h100 && k <= 12'h270) return 1;
        if (k[3:0] == 0 && k >= 12'h300 && k <= 12'h380) return 1;
        return 0;
    endfunction

    function automatic logic wr_virt(input logic [11:0] k);
        if (k inside {12'h020, 12'h080, 12'h0D0, 12'h0E0, 12'h0F0,
                      12'h280, 12'h3E0}) return 1;
        if (k[3:0] == 0 && k >= 12'h310 && k <= 12'h380) return 1;
        return 0;
    endfunction

    task automatic drive(input logic [11:0] off, input int len, input logic wr,
                         input logic evt, input string tag);
        exp_t e;
        logic ex;
        logic [11:0] k;
        int last;
        @(posedge clk); #1;
        acc_valid = 1; acc_offset = off; acc_len = LEN_W'(len);
        acc_write = wr; acc_in_event = evt;
        en_tpr_shadow = sh; en_reg_virt = vr; en_vint_dlv = vi;
        k = {off[11:2], 2'b00};
        last = int'(off) + len - 1;
        e.tp = 0; e.eo = 0; e.rw = 0;
        ex = (len == 0) || (len > 4) || ((last >> 2) != (int'(off) >> 2)) ||
             !sh || (int'(off) >= 'h400) || (m_lock && off != m_off);
        if (!ex) begin
            if (!wr) begin
                ex = vr ? !rd_listed(k) : (off != 12'h080);
            end else if (off == 12'h080) begin
                e.tp = 1;
            end else begin
                logic ok;
                if (k == 12'h0B0 || k == 12'h300) ok = vi || vr;
                else if (wr_virt(k))              ok = vr;
                else                              ok = 0;
                ex = !ok;
                e.rw = ok;
                e.eo = ok && vi && (off == 12'h0B0);
            end
        end
        e.rv = !ex; e.ev = ex;
        e.addr = {vpage_frame, off};
        e.qual = {evt ? 4'h3 : (wr ? 4'h1 : 4'h0), off};
        e.due = cyc + 1;
        e.tag = tag;
        q.push_back(e);
        if (!ex) m_off = off;
        if (e.tp || e.eo || e.rw) m_lock = 1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            acc_valid = 0;
        end
    endtask

    task automatic ack();
        @(posedge clk); #1;
        acc_valid = 0; trap_ack = 1;
        @(posedge clk); #1;
        trap_ack = 0;
        m_lock = 0;
    endtask

    // monitor: results are due one clock after the access
    always @(negedge clk) begin
        if (!rst) begin
            if (q.size() > 0 && q[0].due == cyc) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (remap_valid !== e.rv || exit_valid !== e.ev ||
                    tpr_trap !== e.tp || eoi_trap !== e.eo || regw_trap !== e.rw ||
                    (e.rv && remap_addr !== e.addr) || (e.ev && exit_qual !== e.qual)) begin
                    errors++;
                    $display("FAIL %s: got rv=%b ev=%b t/e/w=%b%b%b addr=%h qual=%h, expected rv=%b ev=%b t/e/w=%b%b%b addr=%h qual=%h",
                             e.tag, remap_valid, exit_valid, tpr_trap, eoi_trap, regw_trap,
                             remap_addr, exit_qual, e.rv, e.ev, e.tp, e.eo, e.rw, e.addr, e.qual);
                end
            end else if (remap_valid || exit_valid || tpr_trap || eoi_trap || regw_trap) begin
                checks++; errors++;
                $display("FAIL R10: unexpected verdict rv=%b ev=%b, expected none", remap_valid, exit_valid);
            end
        end
    end

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        checks++;
        if (remap_valid || exit_valid || tpr_trap || eoi_trap || regw_trap) begin
            errors++;
            $display("FAIL R11: outputs after reset %b%b%b%b%b, expected 00000",
                     remap_valid, exit_valid, tpr_trap, eoi_trap, regw_trap);
        end

        // shadow only
        sh = 1; vr = 0; vi = 0;
        drive(12'h080, 1, 0, 0, "R4 tpr read no reg virt");
        drive(12'h020, 4, 0, 0, "R4 id read no reg virt");
        drive(12'h081, 1, 0, 0, "R4 unaligned tpr read");
        // register virtualization on: read list
        vr = 1;
        drive(12'h020, 4, 0, 0, "R5 id");
        drive(12'h030, 4, 0, 0, "R5 version");
        drive(12'h100, 4, 0, 0, "R5 bank first");
        drive(12'h270, 4, 0, 0, "R5 bank last");
        drive(12'h274, 4, 0, 0, "R5 bank hole");
        drive(12'h3E0, 4, 0, 0, "R5 divide");
        drive(12'h390, 4, 0, 0, "R5 unlisted 390");
        drive(12'h2F0, 4, 0, 0, "R5 unlisted 2F0");
        drive(12'h083, 1, 0, 0, "R5 low bits ignored");
        // R1 word crossing
        drive(12'h082, 4, 0, 0, "R1 cross");
        drive(12'h083, 2, 0, 0, "R1 cross short");
        drive(12'h080, 4, 0, 0, "R1 fits");
        // R2 size, window, shadow
        drive(12'h080, 5, 0, 0, "R2 len 5");
        drive(12'h080, 0, 0, 0, "R2 len 0");
        drive(12'h400, 4, 0, 0, "R2 offset 400");
        sh = 0;
        drive(12'h080, 1, 0, 0, "R2 shadow off");
        sh = 1; vr = 0;
        // R6 TPR write, then R3 lock back to back
        drive(12'h080, 1, 1, 0, "R6 tpr write");
        drive(12'h020, 4, 0, 0, "R3 other offset locked");
        drive(12'h080, 1, 0, 0, "R3 same offset allowed");
        ack();
        vr = 1;
        drive(12'h020, 4, 0, 0, "R11 ack unlocks");
        // R7/R8 writes
        vr = 0; vi = 1;
        drive(12'h0B0, 4, 1, 0, "R7 eoi write delivery on");
        ack();
        drive(12'h300, 4, 1, 0, "R8 icr low delivery only");
        ack();
        drive(12'h020, 4, 1, 0, "R8 id write needs reg virt");
        vi = 0;
        drive(12'h0B0, 4, 1, 0, "R8 eoi write both off");
        drive(12'h0B0, 4, 1, 1, "R9 event code");
        vr = 1;
        drive(12'h0B0, 4, 1, 0, "R7 eoi write delivery off");
        ack();
        drive(12'h020, 4, 1, 0, "R8 id write reg virt");
        ack();
        drive(12'h030, 4, 1, 0, "R8 version not writable");
        drive(12'h100, 4, 1, 0, "R8 bank not writable");
        drive(12'h084, 4, 1, 0, "R8 0x084 not listed");
        drive(12'h2F0, 4, 0, 1, "R9 read event code");
        drive(12'h390, 4, 0, 0, "R9 read code");
        vpage_frame = 20'h12345;
        drive(12'h3E0, 4, 0, 0, "R10 remap frame");
        idle(4);
        if (q.size() != 0) begin
            checks++; errors++;
            $display("FAIL R10: %0d verdicts missing, expected 0", q.size());
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule